// File: doc/BRIEF.md
# Paged OTP Register Controller

This block puts a small register file in front of a one-time-programmable array. The array is modelled as a rewritable register array of `PAGES` pages. Each page is 128 bits wide, which is sixteen bytes or four 32-bit words. Software talks to the block over a simple register bus. It loads four 32-bit staging words and a 16-bit byte-select mask. A single write to the command register then moves a page between the staging words and the array in either direction, or in both directions. A sticky completion flag reports that the transfer has finished. A 32-bit timing word is held for software, and nothing inside the block uses it.

The request side is a valid/ready port. The block accepts a request in any cycle where `req_valid` and `req_ready` are both high. It drops `req_ready` for exactly one cycle after it accepts a command write, because that cycle carries out the transfer. A requester must hold its request until the request is accepted. Every accepted request gets exactly one response, marked by `rsp_valid`, in the next cycle. The response side has no back-pressure, so the requester must take the response in that cycle. Each register enforces its own access width. Any rejected access returns an error code and leaves all state as it was.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, the mask register reads 0xFFFF, the timing word reads 0x00001485, and the command register, the status register and all four staging words read 0. Every array page reads back as all zeros.
- R2: Register offsets are: command 0x00, mask 0x04, status 0x08, timing 0x0C, staging words 0x80/0x84/0x88/0x8C. A command write keeps only the bits under 0x39FF, and a later read returns that kept value. Within the command value, bits [8:0] select the page, and only the low log2(PAGES) bits of that field are used. Bit 11 requests a store and bit 12 requests a fetch.
- R3: A store copies the staging words into the selected page in the cycle after the command is accepted. Staging word 0 is page bits [31:0] and is bytes 0..3, so byte i is page bits [8i+7:8i]. Byte i is copied only when mask bit i is 1. Every other byte of the page keeps its old value.
- R4: A fetch copies the selected page into the staging words. Byte i is copied only when mask bit i is 1. Every other staging byte keeps its old value.
- R5: When one command requests both a store and a fetch, the store is applied first and the fetch then reads the updated page.
- R6: Status bit 0 (done) becomes 1 when the transfer cycle completes. This happens for every accepted command write, including one with neither request bit set. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: The command, mask and status registers accept only 16-bit accesses. The timing word and the staging words accept only 32-bit accesses. A width mismatch on a mapped register returns error code 2.
- R8: The size field is encoded as 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved. A size other than 16 or 32 bits returns error code 1, even at an unmapped offset. A legal size at an unmapped or unaligned offset returns error code 3. An accepted access returns code 0.
- R9: A rejected access returns read data 0. It changes no register, no staging word, no array page and no status bit, and it starts no transfer.
- R10: Exactly one response follows each accepted request, one cycle later. `req_ready` is low only in the single cycle after an accepted command write. Read data is the register's value before that access.
- R11: All 16 mask bits and all 32 timing bits can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_size | input | 2 | Access size code (0 = 8, 1 = 16, 2 = 32, 3 = reserved) |
| req_wdata | input | 32 | Write data; 16-bit registers use bits [15:0] |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_code | output | 2 | 0 ok, 1 bad size, 2 width mismatch, 3 unmapped |
| rsp_rdata | output | 32 | Read data, zero-extended; 0 on writes and errors |

## Verification
Two things can happen in the same transfer cycle: a store into the array and a fetch back into the staging words. The bench provokes this with one command that sets both request bits. It uses a partial byte mask and staging contents that differ from the page. The result is judged against a byte-level shadow model, which applies the store first and then the fetch. A full-mask fetch afterwards confirms what actually landed in the page. A second overlap is the status write-one-to-clear against the done flag being set. The bench exercises it by clearing done around command writes that carry no request bits, and by showing that a write of 0 does not clear the flag.

// File: rtl/otp_regs_pkg.sv
package otp_regs_pkg;

  localparam int unsigned BUS_AW     = 8;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned PAGE_BYTES = 16;
  localparam int unsigned PAGE_W     = PAGE_BYTES * 8;
  localparam int unsigned NUM_WORDS  = PAGE_W / BUS_DW;
  localparam int unsigned WIDX_W     = $clog2(NUM_WORDS);

  // Offsets, expressed as word indices (byte offset >> 2)
  localparam logic [5:0] WI_CMD   = 6'h00;
  localparam logic [5:0] WI_MASK  = 6'h01;
  localparam logic [5:0] WI_STAT  = 6'h02;
  localparam logic [5:0] WI_TIME  = 6'h03;
  localparam logic [5:0] WI_STAGE = 6'h20;

  localparam logic [15:0] CMD_KEEP    = 16'h39FF;
  localparam int unsigned CMD_PG_MSB  = 8;
  localparam int unsigned CMD_STORE   = 11;
  localparam int unsigned CMD_FETCH   = 12;
  localparam int unsigned STAT_DONE   = 0;
  localparam logic [15:0] MASK_INIT   = 16'hFFFF;
  localparam logic [31:0] TIME_INIT   = 32'h0000_1485;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_SIZE     = 2'd1,
    ERR_WIDTH    = 2'd2,
    ERR_UNMAPPED = 2'd3
  } acc_err_e;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_TIME  = 3'd4,
    SEL_STAGE = 3'd5
  } reg_sel_e;

endpackage

// File: rtl/otp_access_check.sv
module otp_access_check
  import otp_regs_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  input  logic [1:0]        size,
  output reg_sel_e          sel,
  output logic [WIDX_W-1:0] word_idx,
  output acc_err_e          code
);

  reg_sel_e raw_sel;
  logic     wide;
  logic     mapped;
  logic     size_legal;
  logic     width_ok;

  always_comb begin
    raw_sel = SEL_NONE;
    wide    = 1'b0;
    mapped  = 1'b0;
    if (addr[1:0] == 2'b00) begin
      unique case (addr[BUS_AW-1:2])
        WI_CMD:  begin raw_sel = SEL_CMD;  mapped = 1'b1; end
        WI_MASK: begin raw_sel = SEL_MASK; mapped = 1'b1; end
        WI_STAT: begin raw_sel = SEL_STAT; mapped = 1'b1; end
        WI_TIME: begin raw_sel = SEL_TIME; mapped = 1'b1; wide = 1'b1; end
        default: begin
          if (addr[BUS_AW-1:2+WIDX_W] == WI_STAGE[5:WIDX_W]) begin
            raw_sel = SEL_STAGE;
            mapped  = 1'b1;
            wide    = 1'b1;
          end
        end
      endcase
    end
  end

  assign word_idx   = addr[2+WIDX_W-1:2];
  assign size_legal = (size == SZ_HALF) || (size == SZ_WORD);
  assign width_ok   = wide ? (size == SZ_WORD) : (size == SZ_HALF);

  // Priority: illegal size, then unmapped offset, then width mismatch
  always_comb begin
    if (!size_legal)    code = ERR_SIZE;
    else if (!mapped)   code = ERR_UNMAPPED;
    else if (!width_ok) code = ERR_WIDTH;
    else                code = ERR_NONE;
  end

  assign sel = (code == ERR_NONE) ? raw_sel : SEL_NONE;

endmodule

// File: rtl/otp_page_store.sv
module otp_page_store
  import otp_regs_pkg::*;
#(
  parameter int unsigned PAGES = 512,
  localparam int unsigned PG_AW = $clog2(PAGES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PG_AW-1:0]      rd_page,
  output logic [PAGE_W-1:0]     rd_data,
  input  logic                  wr_en,
  input  logic [PG_AW-1:0]      wr_page,
  input  logic [PAGE_W-1:0]     wr_data,
  input  logic [PAGE_BYTES-1:0] wr_bmask
);

  logic [PAGE_W-1:0] mem [PAGES];
  logic [PAGE_W-1:0] bit_mask;

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_lane
    assign bit_mask[8*b +: 8] = {8{wr_bmask[b]}};
  end

  assign rd_data = mem[rd_page];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAGES; p++) mem[p] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        if (wr_bmask[b]) mem[wr_page][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  // Bytes outside the mask survive a store
  p_masked_bytes_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((mem[$past(wr_page)] ^ $past(mem[wr_page])) & ~$past(bit_mask)) == '0));

  // Selected bytes carry the staged value after a store
  p_selected_bytes_land_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(wr_page)] & $past(bit_mask)) == ($past(wr_data) & $past(bit_mask))));

endmodule

// File: rtl/otp_stage_regs.sv
module otp_stage_regs
  import otp_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [WIDX_W-1:0]     bus_idx,
  input  logic [BUS_DW-1:0]     bus_wdata,
  input  logic                  load_en,
  input  logic [PAGE_W-1:0]     load_page,
  input  logic [PAGE_BYTES-1:0] load_bmask,
  output logic [PAGE_W-1:0]     stage_page
);

  logic [BUS_DW-1:0] word_q [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (load_en) begin
        for (int b = 0; b < BUS_DW / 8; b++) begin
          if (load_bmask[w*(BUS_DW/8) + b])
            word_q[w][8*b +: 8] <= load_page[w*BUS_DW + 8*b +: 8];
        end
      end else if (bus_we && (bus_idx == WIDX_W'(w))) begin
        word_q[w] <= bus_wdata;
      end
    end
    assign stage_page[w*BUS_DW +: BUS_DW] = word_q[w];
  end

  // The bus is stalled while a transfer runs, so the two writers never meet
  p_no_writer_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && load_en));

  // With no writer active the staging words do not move
  p_stage_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !load_en) |=> $stable(stage_page));

endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_regs_pkg::*;
#(
  parameter int unsigned PAGES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [BUS_DW-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [BUS_DW-1:0] rsp_rdata
);

  localparam int unsigned PG_AW = $clog2(PAGES);

  // Request decode
  reg_sel_e          sel;
  logic [WIDX_W-1:0] widx;
  acc_err_e          code;
  logic              accept;
  logic              ok_wr;

  otp_access_check u_check (
    .addr     (req_addr),
    .size     (req_size),
    .sel      (sel),
    .word_idx (widx),
    .code     (code)
  );

  // Architectural registers
  logic [HALF_W-1:0] cmd_q;
  logic [HALF_W-1:0] mask_q;
  logic [BUS_DW-1:0] time_q;
  logic              done_q;

  // Transfer sequencing
  logic              xfer_pend;
  logic              xfer_store;
  logic              xfer_fetch;
  logic [PG_AW-1:0]  xfer_pg;

  logic [PAGE_W-1:0] stage_page;
  logic [PAGE_W-1:0] arr_rd;
  logic [PAGE_W-1:0] after_store;

  assign req_ready = !xfer_pend;
  assign accept    = req_valid && req_ready;
  assign ok_wr     = accept && req_write && (code == ERR_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      mask_q     <= MASK_INIT;
      time_q     <= TIME_INIT;
      xfer_pend  <= 1'b0;
      xfer_store <= 1'b0;
      xfer_fetch <= 1'b0;
      xfer_pg    <= '0;
    end else begin
      xfer_pend <= 1'b0;
      if (ok_wr) begin
        unique case (sel)
          SEL_CMD: begin
            cmd_q      <= req_wdata[HALF_W-1:0] & CMD_KEEP;
            xfer_pend  <= 1'b1;
            xfer_store <= req_wdata[CMD_STORE];
            xfer_fetch <= req_wdata[CMD_FETCH];
            xfer_pg    <= req_wdata[PG_AW-1:0];
          end
          SEL_MASK: mask_q <= req_wdata[HALF_W-1:0];
          SEL_TIME: time_q <= req_wdata;
          default: ;
        endcase
      end
    end
  end

  // Done flag: set by the transfer cycle, cleared by writing one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (xfer_pend) begin
      done_q <= 1'b1;
    end else if (ok_wr && (sel == SEL_STAT) && req_wdata[STAT_DONE]) begin
      done_q <= 1'b0;
    end
  end

  // Store is applied before the fetch reads the page
  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_merge
    assign after_store[8*b +: 8] = (xfer_store && mask_q[b]) ? stage_page[8*b +: 8]
                                                             : arr_rd[8*b +: 8];
  end

  otp_page_store #(.PAGES(PAGES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_page  (xfer_pg),
    .rd_data  (arr_rd),
    .wr_en    (xfer_pend && xfer_store),
    .wr_page  (xfer_pg),
    .wr_data  (stage_page),
    .wr_bmask (mask_q)
  );

  otp_stage_regs u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (ok_wr && (sel == SEL_STAGE)),
    .bus_idx    (widx),
    .bus_wdata  (req_wdata),
    .load_en    (xfer_pend && xfer_fetch),
    .load_page  (after_store),
    .load_bmask (mask_q),
    .stage_page (stage_page)
  );

  // Read mux
  logic [BUS_DW-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_CMD:   rd_mux = {{(BUS_DW-HALF_W){1'b0}}, cmd_q};
      SEL_MASK:  rd_mux = {{(BUS_DW-HALF_W){1'b0}}, mask_q};
      SEL_STAT:  rd_mux = {{(BUS_DW-1){1'b0}}, done_q};
      SEL_TIME:  rd_mux = time_q;
      SEL_STAGE: rd_mux = stage_page[widx*BUS_DW +: BUS_DW];
      default:   rd_mux = '0;
    endcase
  end

  // Response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= 2'd0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_code  <= code;
        rsp_rdata <= (!req_write && (code == ERR_NONE)) ? rd_mux : '0;
      end
    end
  end

  p_stall_after_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && (sel == SEL_CMD)) |=> !req_ready);

  p_stall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  p_rsp_per_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);

  p_done_on_complete_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pend |=> done_q);

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_wr && (sel == SEL_STAT) && req_wdata[STAT_DONE]) |=> !done_q);

  p_reject_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (code != ERR_NONE)) |=>
      ($stable(cmd_q) && $stable(mask_q) && $stable(time_q) && $stable(done_q) && req_ready));

  p_err_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_code != 2'd0)) |-> (rsp_rdata == '0));

endmodule

// File: tb/sim_otp_page_ctrl.sv
module sim_otp_page_ctrl;

  localparam int TCLK  = 10;
  localparam int NPG   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [7:0]  sm [NPG][16];
  logic [7:0]  sd [16];
  logic [15:0] cur_mask;

  always #(TCLK/2) clk = ~clk;

  otp_page_ctrl #(.PAGES(NPG)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [1:0] code, output logic [31:0] rd);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (rsp_valid !== 1'b1) begin
      n_chk = n_chk + 1; n_bad = n_bad + 1;
      $display("FAIL R10 rsp_valid actual=%b expected=1", rsp_valid);
    end
    code = rsp_code; rd = rsp_rdata;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] wd);
    logic [1:0] c; logic [31:0] r;
    access(1'b1, sz, a, wd, c, r);
    chk("R2 write accepted", {30'd0, c}, 32'd0);
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a, output logic [31:0] v);
    logic [1:0] c;
    access(1'b0, sz, a, 32'd0, c, v);
  endtask

  task automatic set_mask(input logic [15:0] m);
    wr(2'd1, 8'h04, {16'd0, m}); cur_mask = m;
  endtask

  task automatic set_stage(input int k, input logic [31:0] v);
    wr(2'd2, 8'h80 + 8'(4*k), v);
    for (int b = 0; b < 4; b++) sd[4*k+b] = v[8*b +: 8];
  endtask

  // Issue a command and update the shadow: store first, then fetch (R5)
  task automatic cmd(input logic [8:0] pg, input logic st, input logic fe);
    logic [1:0] c; logic [31:0] r; int p;
    access(1'b1, 2'd1, 8'h00, {19'd0, fe, st, 2'b00, pg}, c, r);
    chk("R10 ready low after command", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R10 ready back after transfer", {31'd0, req_ready}, 32'd1);
    chk("R10 no response in transfer cycle", {31'd0, rsp_valid}, 32'd0);
    p = int'(pg) % NPG;
    for (int b = 0; b < 16; b++) if (st && cur_mask[b]) sm[p][b] = sd[b];
    for (int b = 0; b < 16; b++) if (fe && cur_mask[b]) sd[b] = sm[p][b];
  endtask

  task automatic check_stage(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      rd(2'd2, 8'h80 + 8'(4*k), v);
      chk(tag, v, {sd[4*k+3], sd[4*k+2], sd[4*k+1], sd[4*k]});
    end
  endtask

  function automatic logic [1:0] exp_code(input int a, input int sz);
    logic mapped, wide;
    mapped = ((a % 4) == 0) && ((a <= 'h0C) || ((a >= 'h80) && (a <= 'h8C)));
    wide = (a >= 'h0C);
    if (sz != 1 && sz != 2) return 2'd1;
    if (!mapped) return 2'd3;
    if (wide ? (sz != 2) : (sz != 1)) return 2'd2;
    return 2'd0;
  endfunction

  initial begin
    logic [31:0] v;
    logic [1:0]  c;
    logic [31:0] saved [8];
    for (int p = 0; p < NPG; p++) for (int b = 0; b < 16; b++) sm[p][b] = 8'h00;
    for (int b = 0; b < 16; b++) sd[b] = 8'h00;
    cur_mask = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    rd(2'd1, 8'h00, v); chk("R1 command reset", v, 32'h0);
    rd(2'd1, 8'h04, v); chk("R1 mask reset", v, 32'hFFFF);
    rd(2'd1, 8'h08, v); chk("R1 status reset", v, 32'h0);
    rd(2'd2, 8'h0C, v); chk("R1 timing reset", v, 32'h0000_1485);
    check_stage("R1 staging reset");
    for (int k = 0; k < 4; k++) set_stage(k, 32'hA5A5_0000 + 32'(k));
    cmd(9'd5, 1'b0, 1'b1);
    check_stage("R1 blank page fetch");

    // R11 mask and timing fully writable
    set_mask(16'h1234); rd(2'd1, 8'h04, v); chk("R11 mask readback", v, 32'h1234);
    wr(2'd2, 8'h0C, 32'hFEDC_BA98); rd(2'd2, 8'h0C, v); chk("R11 timing readback", v, 32'hFEDC_BA98);
    wr(2'd2, 8'h0C, 32'h0123_4567); rd(2'd2, 8'h0C, v); chk("R11 timing readback 2", v, 32'h0123_4567);

    // R2 kept bits, aliased page (511 -> 15), both requests with mask 0
    set_mask(16'h0000);
    cmd(9'h1FF, 1'b1, 1'b1);
    rd(2'd1, 8'h00, v); chk("R2 command keeps 0x39FF", v, 32'h0000_19FF);
    access(1'b1, 2'd1, 8'h00, 32'h0000_FFFF, c, v);
    @(negedge clk);
    rd(2'd1, 8'h00, v); chk("R2 command all ones", v, 32'h0000_39FF);
    for (int p = 0; p < NPG; p++) for (int b = 0; b < 16; b++)
      if (cur_mask[b]) sm[p % NPG][b] = sm[p % NPG][b];

    // R6 done and write-one-to-clear
    rd(2'd1, 8'h08, v); chk("R6 done after command", v, 32'h1);
    wr(2'd1, 8'h08, 32'h0000_FFFE); rd(2'd1, 8'h08, v); chk("R6 write zero keeps done", v, 32'h1);
    wr(2'd1, 8'h08, 32'h0000_0001); rd(2'd1, 8'h08, v); chk("R6 write one clears", v, 32'h0);
    cmd(9'd2, 1'b0, 1'b0);
    rd(2'd1, 8'h08, v); chk("R6 done on empty command", v, 32'h1);
    wr(2'd1, 8'h08, 32'h0000_0001);

    // R3 masked stores across every page
    for (int p = 0; p < NPG; p++) begin
      for (int k = 0; k < 4; k++) set_stage(k, 32'h9E37_79B1 * 32'(p*4 + k + 1));
      if (p == 0) set_mask(16'hFFFF);
      else if (p == 1) set_mask(16'h0000);
      else set_mask(16'(32'h0000_3C5A * 32'(p)) ^ 16'(16'h1 << p));
      cmd(9'(p), 1'b1, 1'b0);
    end
    // R4 masked fetch then full-page fetch
    for (int p = 0; p < NPG; p++) begin
      for (int k = 0; k < 4; k++) set_stage(k, 32'h5555_0000 ^ 32'(p*16 + k));
      set_mask(16'(32'h0000_C3A5 ^ 32'(p * 16'h0911)));
      cmd(9'(p), 1'b0, 1'b1);
      check_stage("R4 masked fetch");
      set_mask(16'hFFFF);
      cmd(9'(p), 1'b0, 1'b1);
      check_stage("R3 page contents after store");
    end

    // R5 store and fetch in one command
    for (int k = 0; k < 4; k++) set_stage(k, 32'hC0DE_0000 + 32'(k * 32'h1111));
    set_mask(16'h0F0F);
    cmd(9'd3, 1'b1, 1'b1);
    check_stage("R5 staging after store+fetch");
    for (int k = 0; k < 4; k++) set_stage(k, 32'h0);
    set_mask(16'hFFFF);
    cmd(9'd3, 1'b0, 1'b1);
    check_stage("R5 page after store+fetch");

    // R7/R8/R9 response codes for every offset and size (reads)
    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        access(1'b0, 2'(sz), 8'(a), 32'd0, c, v);
        chk((exp_code(a, sz) == 2'd1) ? "R8 size code" :
            (exp_code(a, sz) == 2'd2) ? "R7 width code" : "R8 map code",
            {30'd0, c}, {30'd0, exp_code(a, sz)});
        if (exp_code(a, sz) != 2'd0) chk("R9 error read data zero", v, 32'd0);
      end
    end

    // R9 rejected writes change nothing
    wr(2'd1, 8'h08, 32'h0000_0001);
    for (int r = 0; r < 4; r++) begin
      rd((r == 3) ? 2'd2 : 2'd1, 8'(4*r), saved[r]);
      rd(2'd2, 8'h80 + 8'(4*r), saved[4+r]);
    end
    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        if (exp_code(a, sz) != 2'd0) begin
          access(1'b1, 2'(sz), 8'(a), 32'hFFFF_FFFF, c, v);
          @(negedge clk);
          chk("R9 no stall after rejected write", {31'd0, req_ready}, 32'd1);
        end
      end
    end
    for (int r = 0; r < 4; r++) begin
      rd((r == 3) ? 2'd2 : 2'd1, 8'(4*r), v); chk("R9 register unchanged", v, saved[r]);
      rd(2'd2, 8'h80 + 8'(4*r), v); chk("R9 staging unchanged", v, saved[4+r]);
    end
    for (int p = 0; p < NPG; p++) begin
      cmd(9'(p), 1'b0, 1'b1);
      check_stage("R9 array unchanged");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule